// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the slave side of a two-wire serial memory interface. It oversamples the clock and data lines with the system clock and finds start and stop conditions. It checks the device select byte, takes a two-byte word address and answers read transfers. The data line is open drain: the block only ever pulls it low or lets it go. It holds a persistent 15-bit byte pointer. A read that has no address phase before it carries on from wherever the previous access stopped.

Three read forms are served. A current-address read returns the byte under the pointer. In a sequential read, the slave keeps sending bytes as long as the master acknowledges each one. A random read is a write transfer that carries only the two address bytes, then a repeated start, then a current-address read. The byte array sits outside the block behind a synchronous read port. The pointer is presented on `memAddr`, and the addressed byte is expected back on `memRdData` one system clock later.

Top module: `twm_slave`

## Requirements
- R1: After reset the data line is released (`sdaOe` = 0) and the pointer, visible on `memAddr`, is 0x0000.
- R2: The select byte is bits 7..4 = 1010, bits 3..1 = `devSel`, and bit 0 = direction (1 = read). The byte arrives MSB first. On a match the slave pulls SDA low in the ninth clock. On a mismatch it does not acknowledge, drives nothing, and ignores the bus until the next start, with the pointer unchanged.
- R3: In a write transfer the next two bytes are the word address, high byte first. Each is acknowledged. When the low byte's acknowledge clock ends, the pointer becomes {high[6:0], low}. Bit 7 of the high byte is ignored.
- R4: A current-address read returns the byte at the pointer, MSB first, and the pointer then advances by one.
- R5: Each master acknowledge (SDA low in the ninth clock) after a data byte makes the slave send the byte at the advanced pointer. A master non-acknowledge ends the transfer and the slave releases the bus.
- R6: A random read is address write, repeated start, read select byte. It returns the bytes starting at the written address.
- R7: The pointer wraps from 0x7FFF to 0x0000 when a byte is transferred.
- R8: A stop, or a start in mid-transfer, returns the slave to waiting for a select byte. The pointer is not altered by an address phase that was cut short.
- R9: Bytes that follow the two address bytes in a write transfer are not acknowledged and do not move the pointer.
- R10: The slave changes its SDA drive only while SCL is low. It asserts `sdaOe` only to pull SDA low.
- R11: `memAddr` always shows the pointer. `memRdData` must carry the byte at `memAddr` as of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen on the pin |
| sdaIn | input | 1 | Bus data line as seen on the pin |
| devSel | input | 3 | Static device-select strap compared with the select byte |
| memRdData | input | 8 | Byte read from the array at the previous `memAddr` |
| sdaOe | output | 1 | 1 = pull the data line low, 0 = release it |
| memAddr | output | 15 | Current byte pointer, used as array read address |

## Verification
The bench aims at the places where the pointer can be disturbed. It reads across 0x7FFF. It sends a high address byte with bit 7 set. It stops or restarts halfway through an address phase. It sends an extra data byte after the address. A design that mishandles these would read from a wrapped-wrong or corrupted location on the next current-address read. It addresses the slave with a wrong strap and with a wrong type code, and expects neither an acknowledge nor any driven bits. A slave that answered anyway would put zeros onto the bus. A monitor watches the drive enable across long SCL-high stretches. A slave that moved SDA there would be creating false start or stop conditions.

// File: rtl/twm_pkg.sv
package twm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_DROP,
    ST_TX
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rxShift;
    logic cntUp;
    logic cntClr;
    logic txLoad;
    logic txShift;
    logic hiLoad;
    logic ptrLoad;
    logic ptrInc;
    logic ackCapture;
    logic ackDrive;
    logic relSda;
  } strobe_t;

  // bus events seen by the datapath
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
  } busEvt_t;

endpackage

// File: rtl/twm_dpath.sv
module twm_dpath
  import twm_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  strobe_t           stb,
  input  logic [7:0]        memRdData,
  output busEvt_t           evt,
  output logic              bitCnt8,
  output logic [7:0]        rxByte,
  output logic              masterAck,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] ptr
);

  localparam int CNT_W = 4;
  localparam int HI_W  = ADDR_W - 8;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclD, sdaD, sclQ, sdaQ;
  logic [CNT_W-1:0] bitCnt;
  logic [7:0] rxSh;
  logic [6:0] txSh;
  logic [HI_W-1:0] hiReg;

  assign sclQ = sclSync[SYNC_STAGES-1];
  assign sdaQ = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclQ;
      sdaD    <= sdaQ;
    end
  end

  always_comb begin
    evt.sclRise   = sclQ & ~sclD;
    evt.sclFall   = ~sclQ & sclD;
    evt.startSeen = sclQ & sclD & sdaD & ~sdaQ;
    evt.stopSeen  = sclQ & sclD & ~sdaD & sdaQ;
  end

  assign bitCnt8 = (bitCnt == CNT_W'(8));
  assign rxByte  = rxSh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt    <= '0;
      rxSh      <= '0;
      txSh      <= '0;
      hiReg     <= '0;
      ptr       <= '0;
      masterAck <= 1'b0;
      sdaOe     <= 1'b0;
    end else begin
      if (stb.cntClr)      bitCnt <= '0;
      else if (stb.cntUp)  bitCnt <= bitCnt + 1'b1;

      if (stb.rxShift)     rxSh <= {rxSh[6:0], sdaQ};
      if (stb.hiLoad)      hiReg <= rxSh[HI_W-1:0];

      if (stb.ptrLoad)     ptr <= {hiReg, rxSh};
      else if (stb.ptrInc) ptr <= ptr + 1'b1;

      if (stb.txLoad)       txSh <= memRdData[6:0];
      else if (stb.txShift) txSh <= {txSh[5:0], 1'b0};

      if (stb.ackCapture)  masterAck <= ~sdaQ;

      if (stb.txLoad)        sdaOe <= ~memRdData[7];
      else if (stb.txShift)  sdaOe <= ~txSh[6];
      else if (stb.ackDrive) sdaOe <= 1'b1;
      else if (stb.relSda)   sdaOe <= 1'b0;
    end
  end

  // R10
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclQ);

  // R5
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(8));

endmodule

// File: rtl/twm_ctrl.sv
module twm_ctrl
  import twm_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  busEvt_t    evt,
  input  logic       bitCnt8,
  input  logic [7:0] rxByte,
  input  logic       masterAck,
  input  logic [2:0] devSel,
  output strobe_t    stb,
  output busState_t  state
);

  busState_t stateNxt;
  logic inAck, inAckNxt;
  logic devHit;

  assign devHit = (rxByte[7:4] == DEV_TYPE) && (rxByte[3:1] == devSel);

  always_comb begin
    stb      = '0;
    stateNxt = state;
    inAckNxt = inAck;
    if (evt.stopSeen) begin
      stateNxt   = ST_IDLE;
      inAckNxt   = 1'b0;
      stb.cntClr = 1'b1;
      stb.relSda = 1'b1;
    end else if (evt.startSeen) begin
      stateNxt   = ST_DEV;
      inAckNxt   = 1'b0;
      stb.cntClr = 1'b1;
      stb.relSda = 1'b1;
    end else begin
      case (state)
        ST_DEV, ST_AHI, ST_ALO: begin
          if (!inAck) begin
            if (evt.sclRise && !bitCnt8) begin
              stb.rxShift = 1'b1;
              stb.cntUp   = 1'b1;
            end
            if (evt.sclFall && bitCnt8) begin
              if (state == ST_DEV && !devHit) begin
                stateNxt   = ST_IDLE;
                stb.cntClr = 1'b1;
              end else begin
                stb.ackDrive = 1'b1;
                stb.hiLoad   = (state == ST_AHI);
                inAckNxt     = 1'b1;
              end
            end
          end else if (evt.sclFall) begin
            inAckNxt   = 1'b0;
            stb.cntClr = 1'b1;
            if (state == ST_DEV) begin
              if (rxByte[0]) begin
                stateNxt   = ST_TX;
                stb.txLoad = 1'b1;
              end else begin
                stateNxt   = ST_AHI;
                stb.relSda = 1'b1;
              end
            end else if (state == ST_AHI) begin
              stateNxt   = ST_ALO;
              stb.relSda = 1'b1;
            end else begin
              stateNxt    = ST_DROP;
              stb.ptrLoad = 1'b1;
              stb.relSda  = 1'b1;
            end
          end
        end
        ST_TX: begin
          if (!inAck) begin
            if (evt.sclRise && !bitCnt8) stb.cntUp = 1'b1;
            if (evt.sclFall) begin
              if (bitCnt8) begin
                stb.relSda = 1'b1;
                stb.ptrInc = 1'b1;
                inAckNxt   = 1'b1;
              end else begin
                stb.txShift = 1'b1;
              end
            end
          end else begin
            if (evt.sclRise) stb.ackCapture = 1'b1;
            if (evt.sclFall) begin
              inAckNxt   = 1'b0;
              stb.cntClr = 1'b1;
              if (masterAck) stb.txLoad = 1'b1;
              else           stateNxt   = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      inAck <= 1'b0;
    end else begin
      state <= stateNxt;
      inAck <= inAckNxt;
    end
  end

  // R8
  ack_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    inAck |-> (state != ST_IDLE && state != ST_DROP));

endmodule

// File: rtl/twm_slave.sv
module twm_slave
  import twm_pkg::*;
#(
  parameter int         ADDR_W      = 15,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        devSel,
  input  logic [7:0]        memRdData,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] memAddr
);

  strobe_t   stb;
  busEvt_t   evt;
  busState_t busState;
  logic      bitCnt8;
  logic      masterAck;
  logic [7:0] rxByte;

  twm_ctrl #(.DEV_TYPE(DEV_TYPE)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .evt      (evt),
    .bitCnt8  (bitCnt8),
    .rxByte   (rxByte),
    .masterAck(masterAck),
    .devSel   (devSel),
    .stb      (stb),
    .state    (busState)
  );

  twm_dpath #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .stb      (stb),
    .memRdData(memRdData),
    .evt      (evt),
    .bitCnt8  (bitCnt8),
    .rxByte   (rxByte),
    .masterAck(masterAck),
    .sdaOe    (sdaOe),
    .ptr      (memAddr)
  );

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(memAddr) |-> ($past(busState) == ST_ALO || $past(busState) == ST_TX));

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busState) == ST_TX && !$stable(memAddr)) |->
      memAddr == ADDR_W'($past(memAddr) + 1'b1));

  // R2
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_IDLE || busState == ST_DROP) |-> !sdaOe);

endmodule

// File: tb/tb_twm_slave.sv
module tb_twm_slave;

  localparam int H = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic [2:0] devSel = 3'b101;
  logic sdaOe;
  logic [14:0] memAddr;
  logic [7:0] memRdData;
  logic sdaBus;

  int nChk = 0;
  int nBad = 0;
  int oeViol = 0;
  int sclHighCnt = 0;
  logic prevOe = 1'b0;
  logic [14:0] expPtr;

  always #2 clk = ~clk;

  assign sdaBus = mSda & ~sdaOe;

  twm_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .devSel(devSel),
    .memRdData(memRdData), .sdaOe(sdaOe), .memAddr(memAddr)
  );

  function automatic logic [7:0] memByte(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  always @(posedge clk) memRdData <= memByte(memAddr);

  // R10 monitor: drive must not move during a settled SCL-high phase
  always @(negedge clk) begin
    if (mScl) sclHighCnt = sclHighCnt + 1;
    else      sclHighCnt = 0;
    if (rstN && sdaOe !== prevOe && sclHighCnt > 5) oeViol = oeViol + 1;
    prevOe = sdaOe;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    waitClk(2); mSda = 1'b1; waitClk(H);
    mScl = 1'b1; waitClk(H);
    mSda = 1'b0; waitClk(H);
    mScl = 1'b0;
  endtask

  task automatic stopCond();
    waitClk(2); mSda = 1'b0; waitClk(H);
    mScl = 1'b1; waitClk(H);
    mSda = 1'b1; waitClk(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      waitClk(2); mSda = b[i]; waitClk(H);
      mScl = 1'b1; waitClk(H);
      mScl = 1'b0;
    end
    waitClk(2); mSda = 1'b1; waitClk(H);
    mScl = 1'b1; waitClk(H / 2);
    ack = ~sdaBus;
    waitClk(H / 2);
    mScl = 1'b0;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      waitClk(H);
      mScl = 1'b1; waitClk(H / 2);
      b[i] = sdaBus;
      waitClk(H / 2);
      mScl = 1'b0;
    end
    waitClk(2); mSda = ackIt ? 1'b0 : 1'b1; waitClk(H);
    mScl = 1'b1; waitClk(H);
    mScl = 1'b0;
    waitClk(2); mSda = 1'b1;
  endtask

  function automatic logic [7:0] selByte(input logic rd);
    return {4'b1010, devSel, rd};
  endfunction

  // address phase only; leaves SCL low, no stop
  task automatic addrPhase(input logic [7:0] hi, input logic [7:0] lo);
    logic ack;
    startCond();
    sendByte(selByte(1'b0), ack); chk("R2 select ack (write)", ack, 1);
    sendByte(hi, ack);            chk("R3 high address ack", ack, 1);
    sendByte(lo, ack);            chk("R3 low address ack", ack, 1);
    expPtr = {hi[6:0], lo};
  endtask

  // start + read select + n bytes, last one non-acknowledged, stop
  task automatic readBurst(input int n, input string tag);
    logic ack;
    logic [7:0] b;
    startCond();
    sendByte(selByte(1'b1), ack); chk("R2 select ack (read)", ack, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, b);
      chk(tag, b, memByte(expPtr));
      expPtr = expPtr + 1'b1;
    end
    stopCond();
    chk("R11 pointer on memAddr", memAddr, expPtr);
  endtask

  task automatic randomRead(input logic [7:0] hi, input logic [7:0] lo,
                            input int n, input string tag);
    addrPhase(hi, lo);
    readBurst(n, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    waitClk(4);
    rstN = 1'b1;
    waitClk(3);
    chk("R1 sdaOe after reset", sdaOe, 0);
    chk("R1 pointer after reset", memAddr, 0);
    expPtr = '0;

    // R4 current-address read from reset pointer
    readBurst(1, "R4 current read at 0");

    // R6 random read, then R4 continuation
    randomRead(8'h12, 8'h34, 1, "R6 random read 0x1234");
    readBurst(1, "R4 current read continues");

    // R5 sequential read of six bytes
    randomRead(8'h05, 8'hF0, 6, "R5 sequential byte");

    // R7 wrap across the top of the address space
    randomRead(8'h7F, 8'hFE, 4, "R7 wrap read");
    chk("R7 pointer after wrap", memAddr, 15'h0002);

    // R3 bit 7 of high byte ignored
    randomRead(8'hC3, 8'h21, 1, "R3 high bit ignored");
    chk("R3 pointer from masked address", memAddr, 15'h4322);

    // R2 wrong strap: no ack, nothing driven, pointer kept
    begin
      logic ack;
      logic [7:0] b;
      startCond();
      sendByte({4'b1010, ~devSel, 1'b1}, ack);
      chk("R2 wrong strap not acked", ack, 0);
      recvByte(1'b0, b);
      chk("R2 bus left released", b, 8'hFF);
      stopCond();
      startCond();
      sendByte({4'b1011, devSel, 1'b1}, ack);
      chk("R2 wrong type code not acked", ack, 0);
      stopCond();
      readBurst(1, "R2 pointer unchanged after mismatch");
    end

    // R8 stop in the middle of the address phase
    begin
      logic ack;
      startCond();
      sendByte(selByte(1'b0), ack);
      sendByte(8'h33, ack);
      stopCond();
      readBurst(1, "R8 pointer kept after stop");
      // R8 restart in mid address phase
      startCond();
      sendByte(selByte(1'b0), ack);
      sendByte(8'h44, ack);
      readBurst(1, "R8 pointer kept after restart");
    end

    // R9 extra write data byte is refused
    begin
      logic ack;
      addrPhase(8'h2A, 8'h55);
      sendByte(8'hA5, ack);
      chk("R9 extra data byte not acked", ack, 0);
      stopCond();
      chk("R9 pointer not moved", memAddr, 15'h2A55);
      readBurst(1, "R9 read at loaded address");
    end

    // constrained random mix of random and current reads
    for (int it = 0; it < 12; it++) begin
      int op;
      int n;
      logic [15:0] a;
      op = $urandom_range(0, 1);
      n  = $urandom_range(1, 4);
      a  = 16'($urandom);
      if (op == 0) randomRead(a[15:8], a[7:0], n, "R6 random mix");
      else         readBurst(n, "R5 current/sequential mix");
    end

    chk("R10 drive changes during SCL high", oeViol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule